// File: doc/BRIEF.md
# DMA Request Generator with Latched and Pulsed Handshake

This block turns the end-of-chain completion pulses of eight general conversion triggers into eight DMA request lines. Each trigger has an enable bit. When an enabled trigger's completion pulse arrives, the block sets that trigger's status flag. In the same step it raises that trigger's DMA request. The touch-screen trigger sources have no path into this block.

Software reaches the block through a single 32-bit control word, using a simple write port and a read-back bus. The enable bits sit in bits 7..0. The status flags sit in bits 23..16, with trigger 0 at bit 16. Writing 1 to a status bit clears that flag, and writing 0 leaves it alone. A write that only changes enables therefore carries zeros in bits 23..16 and disturbs no flag.

A mode input selects how a DMA acknowledge clears a request. In pulsed mode the acknowledge alone clears it. In latched mode the source request is the trigger's status flag. The request drops only once an acknowledge has been received and that flag has also been cleared. An acknowledge that arrives while the flag is still set is remembered.

Top module: `dmarq_gen`

## Requirements
- R1: After reset, `dma_req_o` is 0 and `rd_data_o` is 0 (all enables and all status flags clear).
- R2: A cycle with `wr_en_i` high loads `wr_data_i[7:0]` into the enable bits. From the next cycle, the enable bits read back on `rd_data_o[7:0]` and the status flags read back on `rd_data_o[23:16]`, with trigger n at bit 16+n. All other read bits are 0.
- R3: A `done_i[n]` pulse while enable n is set sets status flag n and asserts `dma_req_o[n]` from the next cycle. A pulse on a disabled trigger changes neither.
- R4: A write with bit 16+n set clears status flag n from the next cycle. A write with bit 16+n at 0 leaves flag n unchanged.
- R5: If a completion pulse on enabled trigger n and a clear of flag n fall in the same cycle, flag n is set afterwards.
- R6: With `mode_pulsed_i`=1, `dma_ack_i[n]` high while request n is pending drops `dma_req_o[n]` in the next cycle and leaves the status flag set. An acknowledge with no pending request has no effect.
- R7: With `mode_pulsed_i`=0, an acknowledge while status flag n is still set does not drop request n. The remembered acknowledge drops the request one cycle after the flag clears.
- R8: With `mode_pulsed_i`=0, clearing status flag n without any acknowledge keeps request n asserted. A later acknowledge drops it in the next cycle.
- R9: Clearing enable n deasserts `dma_req_o[n]` from the next cycle and leaves status flag n unchanged. Setting the enable again does not bring back the discarded request.
- R10: The eight triggers are independent: an acknowledge on one trigger leaves the other triggers' requests unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pulsed_i | input | 1 | 1 = acknowledge alone clears a request; 0 = acknowledge plus cleared status flag |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data (enables [7:0], write-1-to-clear flags [23:16]) |
| rd_data_o | output | 32 | Control word read-back |
| done_i | input | 8 | Per-trigger one-cycle chain completion pulses |
| dma_ack_i | input | 8 | Per-trigger DMA acknowledge |
| dma_req_o | output | 8 | Per-trigger DMA request |

## Verification
Completion pulses are sent to enabled and disabled triggers, which tells gating by the enable bit apart from plain pass-through. Acknowledges are applied in both modes, both before and after the status flag is cleared, and only this order tells latched clearing apart from pulsed clearing. Enable-only writes, write-1-to-clear writes and a clear that collides with a set show whether status flags are protected and which action wins. Multi-trigger patterns with a single acknowledge show that the triggers are independent.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
  localparam int unsigned DEF_NUM_TRIG = 8;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_EN_LSB   = 0;
  localparam int unsigned DEF_STAT_LSB = 16;

  typedef enum logic {
    HS_LATCHED = 1'b0,
    HS_PULSED  = 1'b1
  } hs_mode_e;
endpackage

// File: rtl/dmarq_ctrl_regs.sv
module dmarq_ctrl_regs #(
  parameter int unsigned NUM_TRIG = dmarq_pkg::DEF_NUM_TRIG,
  parameter int unsigned DATA_W   = dmarq_pkg::DEF_DATA_W,
  parameter int unsigned EN_LSB   = dmarq_pkg::DEF_EN_LSB,
  parameter int unsigned STAT_LSB = dmarq_pkg::DEF_STAT_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [NUM_TRIG-1:0] done_i,
  output logic [NUM_TRIG-1:0] en_o,
  output logic [NUM_TRIG-1:0] stat_o,
  output logic [NUM_TRIG-1:0] set_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  logic [NUM_TRIG-1:0] en_q, en_d;
  logic [NUM_TRIG-1:0] stat_q, stat_d;
  logic [NUM_TRIG-1:0] clr_vec;
  logic [NUM_TRIG-1:0] set_vec;

  // next-state
  always_comb begin
    set_vec = done_i & en_q;
    clr_vec = wr_en ? wr_data[STAT_LSB +: NUM_TRIG] : '0;
    en_d    = wr_data[EN_LSB +: NUM_TRIG];
    stat_d  = set_vec | (stat_q & ~clr_vec);
  end

  // enable register, written only under the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  // status register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[EN_LSB +: NUM_TRIG]   = en_q;
    rd_data_o[STAT_LSB +: NUM_TRIG] = stat_q;
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign set_o  = set_vec;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_chk
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i[i] && en_q[i]) |=> stat_q[i]);
    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[STAT_LSB+i] && !(done_i[i] && en_q[i])) |=> !stat_q[i]);
    // R4
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !(wr_en && wr_data[STAT_LSB+i])) |=> stat_q[i]);
  end
endmodule

// File: rtl/dmarq_chan.sv
module dmarq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic set_i,
  input  logic src_i,
  input  logic ack_i,
  input  logic pulsed_i,
  output logic req_o
);
  import dmarq_pkg::*;

  logic     req_q, req_d;
  logic     ack_q, ack_d;
  hs_mode_e mode;

  assign mode = hs_mode_e'(pulsed_i);

  // next-state
  always_comb begin
    req_d = req_q;
    ack_d = ack_q;
    if (!en_i) begin
      req_d = 1'b0;
      ack_d = 1'b0;
    end else if (set_i) begin
      req_d = 1'b1;
      ack_d = 1'b0;
    end else if (req_q) begin
      if (mode == HS_PULSED) begin
        ack_d = 1'b0;
        if (ack_i) req_d = 1'b0;
      end else if ((ack_q || ack_i) && !src_i) begin
        req_d = 1'b0;
        ack_d = 1'b0;
      end else begin
        ack_d = ack_q || ack_i;
      end
    end else begin
      ack_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      req_q <= req_d;
      ack_q <= ack_d;
    end
  end

  assign req_o = req_q & en_i;

  // R3
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> req_q);
  // R6
  pulsed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && pulsed_i && ack_i && en_i && !set_i) |=> !req_q);
  // R7
  latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !pulsed_i && src_i && en_i && !set_i) |=> req_q);
  // R9
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !req_q);
endmodule

// File: rtl/dmarq_gen.sv
module dmarq_gen #(
  parameter int unsigned NUM_TRIG = dmarq_pkg::DEF_NUM_TRIG,
  parameter int unsigned DATA_W   = dmarq_pkg::DEF_DATA_W,
  parameter int unsigned EN_LSB   = dmarq_pkg::DEF_EN_LSB,
  parameter int unsigned STAT_LSB = dmarq_pkg::DEF_STAT_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_pulsed_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_TRIG-1:0] done_i,
  input  logic [NUM_TRIG-1:0] dma_ack_i,
  output logic [NUM_TRIG-1:0] dma_req_o
);
  localparam int unsigned STAT_MSB = STAT_LSB + NUM_TRIG - 1;

  logic [NUM_TRIG-1:0] en_w, stat_w, set_w;

  dmarq_ctrl_regs #(
    .NUM_TRIG(NUM_TRIG), .DATA_W(DATA_W), .EN_LSB(EN_LSB), .STAT_LSB(STAT_LSB)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .done_i   (done_i),
    .en_o     (en_w),
    .stat_o   (stat_w),
    .set_o    (set_w),
    .rd_data_o(rd_data_o)
  );

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_chan
    dmarq_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en_w[i]),
      .set_i   (set_w[i]),
      .src_i   (stat_w[i]),
      .ack_i   (dma_ack_i[i]),
      .pulsed_i(mode_pulsed_i),
      .req_o   (dma_req_o[i])
    );
  end

  initial begin
    if (STAT_MSB >= DATA_W) $error("status field exceeds control word");
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> (dma_req_o == '0));
endmodule

// File: tb/dmarq_gen_bench.sv
module dmarq_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pulsed_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [7:0]  done_i = '0;
  logic [7:0]  dma_ack_i = '0;
  logic [7:0]  dma_req_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dmarq_gen u_dmarq_gen (
    .clk(clk), .rst_n(rst_n), .mode_pulsed_i(mode_pulsed_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .done_i(done_i), .dma_ack_i(dma_ack_i), .dma_req_o(dma_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d; tick(); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse(input logic [7:0] m);
    done_i = m; tick(); done_i = '0;
  endtask

  task automatic ack(input logic [7:0] m);
    dma_ack_i = m; tick(); dma_ack_i = '0;
  endtask

  task automatic t_reset();
    chk("R1 req", {24'h0, dma_req_o}, 32'h0);
    chk("R1 rd", rd_data_o, 32'h0);
  endtask

  task automatic t_enable_rw();
    wr(32'h0000_00A5);
    chk("R2 enables", rd_data_o, 32'h0000_00A5);
  endtask

  task automatic t_set();
    pulse(8'h02);
    chk("R3 disabled req", {24'h0, dma_req_o}, 32'h0);
    chk("R3 disabled flag", rd_data_o, 32'h0000_00A5);
    pulse(8'h01);
    chk("R3 req", {24'h0, dma_req_o}, 32'h01);
    chk("R2 R3 flag bit16", rd_data_o, 32'h0001_00A5);
  endtask

  task automatic t_pulsed();
    mode_pulsed_i = 1'b1;
    ack(8'h01);
    chk("R6 drop", {24'h0, dma_req_o}, 32'h0);
    chk("R6 flag kept", rd_data_o, 32'h0001_00A5);
    ack(8'h04);
    chk("R6 idle ack", {24'h0, dma_req_o}, 32'h0);
    wr(32'h0001_00A5);
    chk("R4 clear", rd_data_o, 32'h0000_00A5);
    pulse(8'h04);
    wr(32'h0000_00A5);
    chk("R4 zero write keeps", rd_data_o, 32'h0004_00A5);
    ack(8'h04);
  endtask

  task automatic t_set_wins();
    wr_en_i = 1'b1; wr_data_i = 32'h0004_00A5; done_i = 8'h04;
    tick();
    wr_en_i = 1'b0; wr_data_i = '0; done_i = '0;
    chk("R5 set wins", rd_data_o, 32'h0004_00A5);
    wr(32'h00FF_00A5);
    chk("R5 clear after", rd_data_o, 32'h0000_00A5);
    ack(8'h04);
  endtask

  task automatic t_latched();
    mode_pulsed_i = 1'b0;
    pulse(8'h20);
    ack(8'h20);
    chk("R7 hold after ack", {24'h0, dma_req_o}, 32'h20);
    tick();
    chk("R7 still held", {24'h0, dma_req_o}, 32'h20);
    wr(32'h0020_00A5);
    chk("R7 flag cleared", rd_data_o, 32'h0000_00A5);
    chk("R7 one cycle lag", {24'h0, dma_req_o}, 32'h20);
    tick();
    chk("R7 drop", {24'h0, dma_req_o}, 32'h0);
    pulse(8'h80);
    wr(32'h0080_00A5);
    tick(); tick();
    chk("R8 no ack held", {24'h0, dma_req_o}, 32'h80);
    ack(8'h80);
    chk("R8 ack drop", {24'h0, dma_req_o}, 32'h0);
  endtask

  task automatic t_disable();
    pulse(8'h01);
    chk("R9 raised", {24'h0, dma_req_o}, 32'h01);
    wr(32'h0000_00A4);
    chk("R9 req off", {24'h0, dma_req_o}, 32'h0);
    chk("R9 flag kept", rd_data_o, 32'h0001_00A4);
    wr(32'h0000_00A5);
    chk("R9 no revival", {24'h0, dma_req_o}, 32'h0);
    wr(32'h00FF_00A5);
  endtask

  task automatic t_indep();
    mode_pulsed_i = 1'b1;
    pulse(8'h05);
    chk("R10 both", {24'h0, dma_req_o}, 32'h05);
    ack(8'h01);
    chk("R10 other kept", {24'h0, dma_req_o}, 32'h04);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_enable_rw();
    t_set();
    t_pulsed();
    t_set_wins();
    t_latched();
    t_disable();
    t_indep();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule